// File: doc/BRIEF.md
# Two-Phase Randomized Hypercube Route Decision

This block decides, for one node of a binary hypercube with 2^DIM_W nodes, where a packet goes next. Two nodes are neighbours when their addresses differ in exactly one bit, so each hop moves along one dimension. Routing straight to the destination in dimension order can pile many flows onto the same links for some permutations. To avoid this, every route runs in two legs. The first leg goes to a pseudo-random intermediate node and the second goes on to the real destination. Each leg needs at most DIM_W hops. The decision is made locally from the header and the node's own address, without any global view of the network.

When a packet enters the network (inject), the block takes the intermediate address from an on-block LFSR and clears the phase bit. A node on the path compares its own address with the current target: the intermediate node in phase 0 and the destination in phase 1. It sends the packet along the lowest dimension in which they differ. When phase 0 reaches the intermediate node, the phase turns to 1 in the same decision. When phase 1 reaches the destination, the block signals local delivery. The decision is combinational, and its result is held in a one-cycle output register.

Top module: `hcube_route_unit`

## Requirements
- R1: While rst_n is low, and at the first sample after it, out_valid and out_deliver are 0.
- R2: A header presented with in_valid=1 at a rising edge appears on the outputs with out_valid=1 after exactly that edge. With in_valid=0, out_valid is 0 after the edge.
- R3: On a valid inject, in_mid and in_phase are ignored. The outgoing intermediate is the current LFSR state, and the outgoing phase is 0 unless that state equals node_addr.
- R4: The LFSR resets to LFSR_SEED (1) and steps only on a valid inject, as s <= {s[2:0], s[3]^s[2]} for DIM_W=4. It never holds zero, and a raised in_inject with in_valid=0 does not step it.
- R5: In phase 0 with node_addr != intermediate, out_dim is the binary index of the lowest set bit of (intermediate XOR node_addr), and out_deliver=0. This holds even when node_addr equals the destination.
- R6: In phase 0 with node_addr == intermediate, out_phase becomes 1 and the dimension is chosen toward the destination in the same decision.
- R7: In phase 1 with node_addr != destination, out_dim is the index of the lowest set bit of (destination XOR node_addr).
- R8: In phase 1 with node_addr == destination, out_deliver=1 and out_dim=0.
- R9: out_dest always equals the incoming destination. On a non-inject header, out_mid equals in_mid.
- R10: Following the chosen dimensions hop by hop, every packet is delivered at its destination after at most 2*DIM_W hops.
- R11: A non-inject header that arrives in phase 1 leaves in phase 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| node_addr | input | DIM_W | Address of this node |
| in_valid | input | 1 | Incoming header is valid |
| in_inject | input | 1 | Header is a new packet entering here |
| in_dest | input | DIM_W | Final destination |
| in_mid | input | DIM_W | Intermediate node (ignored on inject) |
| in_phase | input | 1 | 0 = heading to intermediate, 1 = to destination |
| out_valid | output | 1 | Registered decision is valid |
| out_deliver | output | 1 | Packet is for this node |
| out_dim | output | IDX_W | Dimension to forward along |
| out_dest | output | DIM_W | Updated destination |
| out_mid | output | DIM_W | Updated intermediate |
| out_phase | output | 1 | Updated phase |

## Verification
The assertions take node_addr as constant across the edge that registers a header, since they compare outputs with the previous cycle's node_addr. They also take in_valid to be low in the cycle reset is released. The stimulus changes node_addr only on the falling edge together with the header, and holds in_valid low throughout reset. Packets are walked hop by hop with node_addr advanced along the reported dimension. Random stand-alone headers, including phase-1 headers carrying arbitrary intermediates, cover the cases the walks do not reach.

// File: rtl/hcr_pkg.sv
package hcr_pkg;

   // Feedback mask for a maximal-length Fibonacci LFSR, shifting left,
   // feedback = XOR of state bits selected by the mask.
   function automatic logic [7:0] lfsr_taps(input int width);
      case (width)
         2:       return 8'h03;
         3:       return 8'h06;
         4:       return 8'h0C;
         5:       return 8'h14;
         6:       return 8'h30;
         7:       return 8'h60;
         8:       return 8'hB8;
         default: return 8'h00;
      endcase
   endfunction

   typedef enum logic [1:0] {
      ACT_TO_MID  = 2'd0,
      ACT_TO_DEST = 2'd1,
      ACT_LOCAL   = 2'd2
   } hcr_act_e;

endpackage

// File: rtl/hcr_lfsr.sv
module hcr_lfsr #(
   parameter int W    = 4,
   parameter int SEED = 1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         adv,
   output logic [W-1:0] state
);
   localparam logic [7:0]   TAPS_ALL = hcr_pkg::lfsr_taps(W);
   localparam logic [W-1:0] TAPS     = TAPS_ALL[W-1:0];
   localparam logic [W-1:0] SEED_V   = W'(SEED);

   generate
      if (W < 2 || W > 8) begin : g_bad_width
         $error("hcr_lfsr: W must lie in 2..8");
      end
      if (SEED <= 0 || SEED >= (1 << W)) begin : g_bad_seed
         $error("hcr_lfsr: SEED must be a nonzero W-bit value");
      end
   endgenerate

   logic fb;
   assign fb = ^(state & TAPS);

   always_ff @(posedge clk) begin
      if (!rst_n)   state <= SEED_V;
      else if (adv) state <= {state[W-2:0], fb};
   end

   AST_LFSR_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
      state != '0); // R4
   AST_LFSR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !adv |=> $stable(state)); // R4
endmodule

// File: rtl/hcr_low_pick.sv
module hcr_low_pick #(
   parameter int W  = 4,
   parameter int IW = 2
) (
   input  logic [W-1:0]  vec,
   output logic          any,
   output logic [IW-1:0] idx
);
   generate
      if ((1 << IW) < W) begin : g_bad_iw
         $error("hcr_low_pick: IW too narrow for W");
      end
   endgenerate

   logic [W-1:0] hot;
   assign hot = vec & (~vec + W'(1));
   assign any = |vec;

   genvar b, i;
   generate
      for (b = 0; b < IW; b++) begin : g_bit
         logic [W-1:0] sel;
         for (i = 0; i < W; i++) begin : g_sel
            assign sel[i] = ((i >> b) & 1) != 0;
         end
         assign idx[b] = |(hot & sel);
      end
   endgenerate
endmodule

// File: rtl/hcr_decide.sv
module hcr_decide #(
   parameter int W  = 4,
   parameter int IW = 2
) (
   input  logic [W-1:0]  node,
   input  logic [W-1:0]  dest,
   input  logic [W-1:0]  mid_in,
   input  logic          phase_in,
   input  logic          inject,
   input  logic [W-1:0]  rnd,
   output logic          deliver,
   output logic [IW-1:0] dim,
   output logic [W-1:0]  mid_out,
   output logic          phase_out,
   output hcr_pkg::hcr_act_e act
);
   logic         ph_eff;
   logic         at_mid;
   logic [W-1:0] target;
   logic         differs;

   assign mid_out   = inject ? rnd : mid_in;
   assign ph_eff    = inject ? 1'b0 : phase_in;
   assign at_mid    = !ph_eff && (node == mid_out);
   assign phase_out = ph_eff | at_mid;
   assign target    = phase_out ? dest : mid_out;

   hcr_low_pick #(.W(W), .IW(IW)) pick_i (
      .vec (target ^ node),
      .any (differs),
      .idx (dim)
   );

   assign deliver = !differs;

   always_comb begin
      if (deliver)        act = hcr_pkg::ACT_LOCAL;
      else if (phase_out) act = hcr_pkg::ACT_TO_DEST;
      else                act = hcr_pkg::ACT_TO_MID;
   end
endmodule

// File: rtl/hcube_route_unit.sv
module hcube_route_unit #(
   parameter int DIM_W      = 4,
   parameter int LFSR_SEED  = 1,
   localparam int IDX_W     = (DIM_W > 1) ? $clog2(DIM_W) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [DIM_W-1:0] node_addr,
   input  logic             in_valid,
   input  logic             in_inject,
   input  logic [DIM_W-1:0] in_dest,
   input  logic [DIM_W-1:0] in_mid,
   input  logic             in_phase,
   output logic             out_valid,
   output logic             out_deliver,
   output logic [IDX_W-1:0] out_dim,
   output logic [DIM_W-1:0] out_dest,
   output logic [DIM_W-1:0] out_mid,
   output logic             out_phase
);
   generate
      if (DIM_W < 2 || DIM_W > 8) begin : g_bad_dim
         $error("hcube_route_unit: DIM_W must lie in 2..8");
      end
   endgenerate

   logic [DIM_W-1:0] rnd;
   logic             d_deliver;
   logic [IDX_W-1:0] d_dim;
   logic [DIM_W-1:0] d_mid;
   logic             d_phase;
   hcr_pkg::hcr_act_e d_act;

   hcr_lfsr #(.W(DIM_W), .SEED(LFSR_SEED)) lfsr_i (
      .clk   (clk),
      .rst_n (rst_n),
      .adv   (in_valid & in_inject),
      .state (rnd)
   );

   hcr_decide #(.W(DIM_W), .IW(IDX_W)) dec_i (
      .node      (node_addr),
      .dest      (in_dest),
      .mid_in    (in_mid),
      .phase_in  (in_phase),
      .inject    (in_inject),
      .rnd       (rnd),
      .deliver   (d_deliver),
      .dim       (d_dim),
      .mid_out   (d_mid),
      .phase_out (d_phase),
      .act       (d_act)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid   <= 1'b0;
         out_deliver <= 1'b0;
         out_dim     <= '0;
         out_dest    <= '0;
         out_mid     <= '0;
         out_phase   <= 1'b0;
      end else begin
         out_valid   <= in_valid;
         out_deliver <= in_valid && (d_act == hcr_pkg::ACT_LOCAL);
         out_dim     <= d_dim;
         out_dest    <= in_dest;
         out_mid     <= d_mid;
         out_phase   <= d_phase;
      end
   end

   AST_DEST_PASS: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> out_dest == $past(in_dest)); // R9
   AST_MID_PASS: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !$past(in_inject) |-> out_mid == $past(in_mid)); // R9
   AST_PHASE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && $past(in_phase && !in_inject) |-> out_phase); // R11
   AST_DELIVER_AT_DEST: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && out_deliver |-> out_phase && out_dest == $past(node_addr)); // R8
   AST_LEG0_MOVES: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_phase |-> !out_deliver && out_mid != $past(node_addr)); // R5
   AST_INJECT_FRESH: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && $past(in_inject) && out_mid != $past(node_addr) |-> !out_phase); // R3
endmodule

// File: tb/hcube_route_unit_tb_top.sv
`timescale 1ns/1ps
module hcube_route_unit_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [3:0] node_addr = '0;
   logic       in_valid = 1'b0;
   logic       in_inject = 1'b0;
   logic [3:0] in_dest = '0;
   logic [3:0] in_mid = '0;
   logic       in_phase = 1'b0;
   logic       out_valid, out_deliver, out_phase;
   logic [1:0] out_dim;
   logic [3:0] out_dest, out_mid;

   always #10 clk = ~clk;

   hcube_route_unit dut_i (
      .clk(clk), .rst_n(rst_n), .node_addr(node_addr),
      .in_valid(in_valid), .in_inject(in_inject), .in_dest(in_dest),
      .in_mid(in_mid), .in_phase(in_phase),
      .out_valid(out_valid), .out_deliver(out_deliver), .out_dim(out_dim),
      .out_dest(out_dest), .out_mid(out_mid), .out_phase(out_phase)
   );

   int n_cmp = 0;
   int n_bad = 0;
   bit finished = 0;

   // reference state
   logic [3:0] m_lfsr;
   bit have_e = 0;
   int e_v, e_del, e_dim, e_dest, e_mid, e_ph, e_inj, e_sw;

   task automatic chk(input string tag, input int act, input int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic compare_prev();
      if (!have_e) return;
      chk("R2 out_valid", int'(out_valid), e_v);
      if (e_v != 0) begin
         chk("R8 out_deliver", int'(out_deliver), e_del);
         chk(e_del != 0 ? "R8 out_dim" : (e_ph != 0 ? "R7 out_dim" : "R5 out_dim"),
             int'(out_dim), e_dim);
         chk("R9 out_dest", int'(out_dest), e_dest);
         chk(e_inj != 0 ? "R4 out_mid" : "R9 out_mid", int'(out_mid), e_mid);
         chk(e_sw != 0 ? "R6 out_phase" : (e_inj != 0 ? "R3 out_phase" : "R11 out_phase"),
             int'(out_phase), e_ph);
      end
   endtask

   // one clock: check the previous decision, drive a new header, predict it
   task automatic step(input int v, input int inj, input int node, input int dst,
                       input int mid, input int ph);
      int m, p, tgt, diff;
      @(negedge clk);
      compare_prev();
      node_addr = 4'(node); in_valid = 1'(v); in_inject = 1'(inj);
      in_dest = 4'(dst); in_mid = 4'(mid); in_phase = 1'(ph);
      m = mid; p = ph; e_sw = 0; e_inj = (v != 0 && inj != 0) ? 1 : 0;
      if (inj != 0) begin
         m = int'(m_lfsr); p = 0;
         if (v != 0) m_lfsr = {m_lfsr[2:0], m_lfsr[3] ^ m_lfsr[2]};
      end
      if (p == 0 && node == m) begin p = 1; e_sw = 1; end
      tgt = (p != 0) ? dst : m;
      diff = tgt ^ node;
      e_del = (diff == 0) ? 1 : 0;
      e_dim = 0;
      for (int i = 3; i >= 0; i--) if (((diff >> i) & 1) != 0) e_dim = i;
      e_v = v; e_dest = dst; e_mid = m; e_ph = p;
      have_e = 1;
   endtask

   task automatic walk(input int src, input int dst);
      int node, mid, ph, hops;
      bit done;
      node = src; mid = 0; ph = 0; hops = 0; done = 0;
      step(1, 1, node, dst, 0, 0);
      for (int k = 0; k < 20 && !done; k++) begin
         if (e_del != 0) done = 1;
         else begin
            node = node ^ (1 << e_dim); mid = e_mid; ph = e_ph; hops++;
            step(1, 0, node, dst, mid, ph);
         end
      end
      chk("R10 delivered", int'(done), 1);
      chk("R10 hops within 2n", (hops <= 8) ? 1 : 0, 1);
      chk("R10 final node", node, dst);
   endtask

   task automatic report();
      if (!finished) begin
         finished = 1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
   end

   initial begin
      m_lfsr = 4'd1;
      repeat (4) @(negedge clk);
      chk("R1 out_valid in reset", int'(out_valid), 0);
      chk("R1 out_deliver in reset", int'(out_deliver), 0);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 out_valid after reset", int'(out_valid), 0);
      // R3/R6: first draw is 1, injected at node 1 -> leg 0 ends at once
      step(1, 1, 1, 6, 9, 1);
      // R4: raised inject without valid must not step the LFSR
      step(0, 1, 3, 3, 0, 0);
      step(0, 1, 5, 2, 0, 0);
      // R4: next draw is 2; R5 node equals destination but leg 0 continues
      step(1, 1, 0, 0, 7, 1);
      // R8: phase 1 at destination
      step(1, 0, 12, 12, 3, 1);
      // R5: phase 0, node == dest, mid elsewhere
      step(1, 0, 5, 5, 8, 0);
      // R7/R11: phase 1 with arbitrary intermediate
      step(1, 0, 2, 13, 2, 1);
      // R6: phase 0 reaches intermediate, destination equal too -> deliver
      step(1, 0, 9, 9, 9, 0);
      step(0, 0, 0, 0, 0, 0);
      for (int s = 0; s < 16; s++) walk(s, 15 - s);
      for (int p = 0; p < 40; p++) walk($urandom_range(15), $urandom_range(15));
      for (int r = 0; r < 400; r++)
         step($urandom_range(1), ($urandom_range(3) == 0) ? 1 : 0,
              $urandom_range(15), $urandom_range(15), $urandom_range(15),
              $urandom_range(1));
      step(0, 0, 0, 0, 0, 0);
      step(0, 0, 0, 0, 0, 0);
      report();
   end
endmodule